// File: doc/BRIEF.md
# Banked Video Memory Mapping Controller

The block holds one 8-bit configuration byte for each of nine video memory banks (numbered 0 to 8). From each byte it works out which slots of several address spaces the bank owns:
- the direct CPU window
- background and object spaces for two display engines
- extended-palette slots for backgrounds and objects
- texture and texture-palette slots
- a window for a secondary processor

A combinational lookup port takes a space code and a slot index. It returns the owning bank and the offset inside that bank, in units of the space's slot. It also returns a mask of every bank that claims the slot, so that a memory wrapper can OR their read data together. When no bank claims the slot, everything on the port reads as zero. The bank memories themselves sit outside this block.

Ownership is decoded afresh from the nine bytes every cycle. Reconfiguring a bank therefore drops its old slots and leaves slots still claimed by other banks untouched. Writing the same byte again changes nothing.

Top module: `vram_bank_map`

## Requirements
- R1: After reset every byte is zero, so every bank is disabled and every lookup misses.
- R2: Configuration byte layout and write port.
  - Bit 7 enables the bank, bits 2:0 select the mode and bits 4:3 give the offset field `o`.
  - `cfg_sel` values 0 to 8 pick banks 0 to 8; values 9 to 15 are ignored.
  - A write seen at a rising edge affects lookups from that edge on.
  - Space codes on `lk_space`:
    - 0 CPU window (64 slots)
    - 1 engine-A background (32 slots)
    - 2 engine-A objects (32 slots)
    - 3 engine-B background (32 slots)
    - 4 engine-B objects (32 slots)
    - 5 secondary window (16 slots)
    - 6 engine-A background extended palette (4 slots)
    - 7 engine-B background extended palette (4 slots)
    - 8 engine-A object extended palette (1 slot)
    - 9 engine-B object extended palette (1 slot)
    - 10 texture (4 slots)
    - 11 texture palette (6 slots)
    - codes 12 to 15 always miss.
- R3: Mode 0 maps a bank into space 0 at a fixed base and ignores the offset field.
  - Banks 0 to 8 have bases 0, 8, 16, 24, 32, 36, 37, 38 and 40.
  - Banks 0 to 8 cover 8, 8, 8, 8, 4, 1, 1, 2 and 1 consecutive slots from that base.
- R4: Mode 1 maps into space 1.
  - Banks 0 to 3 cover 8 slots from 8·o.
  - Bank 4 covers slots 0 to 3.
  - Banks 5 and 6 cover one slot at position p, where p = 0, 1, 4, 5 for o = 0 to 3.
- R5: Mode 2 of banks 0, 1, 4, 5 and 6 maps into space 2 and repeats every 16 slots.
  - Banks 0 and 1 start at 8·o when o < 2 and own nothing when o ≥ 2.
  - Bank 4 starts at 0 and covers 4 slots.
  - Banks 5 and 6 own position p.
- R6: Banks 2 and 3 have two further modes.
  - Mode 2 maps them into space 5 at slots 8·o to 8·o+7 when o < 2, and to nothing otherwise.
  - Mode 4 maps bank 2 into every slot of space 3 and bank 3 into every slot of space 4, repeating every 8 slots.
- R7: Banks 7 and 8 serve engine B.
  - Bank 7, mode 1: space 3 slots with slot mod 4 in {0,1}.
  - Bank 7, mode 2: space 7 slots 0 to 3.
  - Bank 8, mode 1: space 3 slots with slot mod 4 = 2.
  - Bank 8, mode 2: all 32 slots of space 4.
  - Bank 8, mode 3: space 9 slot 0.
- R8: Palette and texture modes.
  - Banks 0 to 3, mode 3: space 10 slot o.
  - Bank 4, mode 3: space 11 slots 0 to 3.
  - Bank 4, mode 4: space 6 slots 0 to 3.
  - Banks 5 and 6, mode 3: space 11 slot p.
  - Banks 5 and 6, mode 4: space 6 slots 2·o[0] and 2·o[0]+1.
  - Banks 5 and 6, mode 5: space 8 slot 0.
- R9: A disabled bank, or a mode not listed above, owns nothing. A miss returns `lk_hit`=0, `lk_bank`=0, `lk_offset`=0 and `lk_mask`=0.
- R10: `lk_mask` bit b is set when bank b claims the looked-up slot. `lk_bank` is the lowest such index.
- R11: Rewriting a bank releases only that bank's previous slots; a slot also claimed by another bank stays owned by it. Rewriting the same byte leaves every lookup unchanged.
- R12: `lk_offset` is the winning bank's relative slot: (slot − first slot of the copy) within the repeating copy that holds the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Bank number to write |
| cfg_data | input | 8 | Configuration byte |
| lk_space | input | 4 | Space code for lookup |
| lk_slot | input | 6 | Slot index for lookup |
| lk_hit | output | 1 | Some bank owns the slot |
| lk_bank | output | 4 | Winning bank |
| lk_offset | output | 6 | Bank-relative slot of the winner |
| lk_mask | output | 9 | All claiming banks |

## Verification
The bench sweeps every space and slot for each scenario and compares against a loop-based reference model on every cycle. It targets the following corner cases:
- Offset values 2 and 3 in object and secondary-window modes. A design that wrapped them would map those banks onto low slots.
- Repetition periods of 16, 8, 4 and 1 slots. An off-by-one mask would leave gaps or double copies.
- Overlaps between banks. A wrong priority would report a higher bank, or drop a claimant from the mask.
- Release on rewrite and out-of-range selects. A design with a stale ownership table would keep returning the old bank.
- Modes with no entry. A design that decoded them anyway would map the bank somewhere.

// File: rtl/vram_bank_map.sv
module vram_bank_map #(
  parameter int BANKS   = 9,
  parameter int SPACE_W = 4,
  parameter int SLOT_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [3:0]         cfg_sel,
  input  logic [7:0]         cfg_data,
  input  logic [SPACE_W-1:0] lk_space,
  input  logic [SLOT_W-1:0]  lk_slot,
  output logic               lk_hit,
  output logic [3:0]         lk_bank,
  output logic [SLOT_W-1:0]  lk_offset,
  output logic [BANKS-1:0]   lk_mask
);
  localparam logic [SPACE_W-1:0] SP_CPU = 0, SP_ABG = 1, SP_AOBJ = 2, SP_BBG = 3,
    SP_BOBJ = 4, SP_SUB = 5, SP_ABGX = 6, SP_BBGX = 7, SP_AOBJX = 8, SP_BOBJX = 9,
    SP_TEX = 10, SP_TEXP = 11;

  typedef struct packed {
    logic               ok;
    logic [SPACE_W-1:0] sp;
    logic [SLOT_W-1:0]  st;
    logic [SLOT_W:0]    lim;
    logic [SLOT_W-1:0]  msk;
    logic [3:0]         sz;
  } claim_t;

  function automatic claim_t mk(input logic [SPACE_W-1:0] sp, input logic [SLOT_W-1:0] st,
                                input logic [SLOT_W:0] lim, input logic [SLOT_W-1:0] msk,
                                input logic [3:0] sz);
    return {1'b1, sp, st, lim, msk, sz};
  endfunction

  function automatic logic [SLOT_W-1:0] cpu_base(input logic [3:0] b);
    case (b)
      4'd0: return 6'd0;
      4'd1: return 6'd8;
      4'd2: return 6'd16;
      4'd3: return 6'd24;
      4'd4: return 6'd32;
      4'd5: return 6'd36;
      4'd6: return 6'd37;
      4'd7: return 6'd38;
      default: return 6'd40;
    endcase
  endfunction

  function automatic logic [3:0] bank_slots(input logic [3:0] b);
    case (b)
      4'd0, 4'd1, 4'd2, 4'd3: return 4'd8;
      4'd4: return 4'd4;
      4'd7: return 4'd2;
      default: return 4'd1;
    endcase
  endfunction

  function automatic claim_t decode(input logic [3:0] b, input logic [7:0] r);
    claim_t c;
    logic [1:0] o;
    logic [SLOT_W-1:0] ad, fg, xp;
    c  = '0;
    o  = r[4:3];
    ad = {1'b0, o, 3'b000};
    fg = {3'b000, o[1], 1'b0, o[0]};
    xp = {4'b0000, o[0], 1'b0};
    if (r[7]) begin
      if (r[2:0] == 3'd0) c = mk(SP_CPU, cpu_base(b), 7'd64, 6'd63, bank_slots(b));
      else case (b)
        4'd0, 4'd1:
          case (r[2:0])
            3'd1: c = mk(SP_ABG, ad, 7'd32, 6'd31, 4'd8);
            3'd2: if (!o[1]) c = mk(SP_AOBJ, ad, 7'd32, 6'd15, 4'd8);
            3'd3: c = mk(SP_TEX, {4'b0, o}, {5'b0, o} + 7'd1, 6'd63, 4'd1);
            default: ;
          endcase
        4'd2, 4'd3:
          case (r[2:0])
            3'd1: c = mk(SP_ABG, ad, 7'd32, 6'd31, 4'd8);
            3'd2: if (!o[1]) c = mk(SP_SUB, ad, 7'd16, 6'd63, 4'd8);
            3'd3: c = mk(SP_TEX, {4'b0, o}, {5'b0, o} + 7'd1, 6'd63, 4'd1);
            3'd4: c = mk((b == 4'd2) ? SP_BBG : SP_BOBJ, 6'd0, 7'd32, 6'd7, 4'd8);
            default: ;
          endcase
        4'd4:
          case (r[2:0])
            3'd1: c = mk(SP_ABG, 6'd0, 7'd32, 6'd31, 4'd4);
            3'd2: c = mk(SP_AOBJ, 6'd0, 7'd32, 6'd15, 4'd4);
            3'd3: c = mk(SP_TEXP, 6'd0, 7'd4, 6'd63, 4'd4);
            3'd4: c = mk(SP_ABGX, 6'd0, 7'd4, 6'd63, 4'd4);
            default: ;
          endcase
        4'd5, 4'd6:
          case (r[2:0])
            3'd1: c = mk(SP_ABG, fg, 7'd32, 6'd31, 4'd1);
            3'd2: c = mk(SP_AOBJ, fg, 7'd32, 6'd15, 4'd1);
            3'd3: c = mk(SP_TEXP, fg, {1'b0, fg} + 7'd1, 6'd63, 4'd1);
            3'd4: c = mk(SP_ABGX, xp, {1'b0, xp} + 7'd2, 6'd63, 4'd2);
            3'd5: c = mk(SP_AOBJX, 6'd0, 7'd1, 6'd63, 4'd1);
            default: ;
          endcase
        4'd7:
          case (r[2:0])
            3'd1: c = mk(SP_BBG, 6'd0, 7'd32, 6'd3, 4'd2);
            3'd2: c = mk(SP_BBGX, 6'd0, 7'd4, 6'd63, 4'd4);
            default: ;
          endcase
        default:
          case (r[2:0])
            3'd1: c = mk(SP_BBG, 6'd2, 7'd32, 6'd3, 4'd1);
            3'd2: c = mk(SP_BOBJ, 6'd0, 7'd32, 6'd0, 4'd1);
            3'd3: c = mk(SP_BOBJX, 6'd0, 7'd1, 6'd63, 4'd1);
            default: ;
          endcase
      endcase
    end
    return c;
  endfunction

  logic [7:0]        cfg_q [BANKS];
  logic [BANKS-1:0]  own;
  logic [SLOT_W-1:0] rel [BANKS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BANKS; i++) cfg_q[i] <= '0;
    end else if (cfg_we && cfg_sel < 4'(BANKS)) begin
      cfg_q[cfg_sel] <= cfg_data;
    end
  end

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    claim_t            c;
    logic [SLOT_W-1:0] d;
    assign c = decode(4'(g), cfg_q[g]);
    assign d = lk_slot - c.st;
    assign own[g] = c.ok && (lk_space == c.sp) && (lk_slot >= c.st) &&
                    ({1'b0, lk_slot} < c.lim) && ((d & c.msk) < {2'b00, c.sz});
    assign rel[g] = d & c.msk;
  end

  always_comb begin
    lk_bank   = '0;
    lk_offset = '0;
    for (int i = BANKS - 1; i >= 0; i--) begin
      if (own[i]) begin
        lk_bank   = 4'(i);
        lk_offset = rel[i];
      end
    end
  end

  assign lk_mask = own;
  assign lk_hit  = |own;
endmodule

module vram_bank_map_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [3:0] cfg_sel,
  input logic [3:0] lk_space,
  input logic [5:0] lk_slot,
  input logic       lk_hit,
  input logic [3:0] lk_bank,
  input logic [5:0] lk_offset,
  input logic [8:0] lk_mask
);
  p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (lk_mask == 9'd0));

  p_miss_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_bank == 4'd0 && lk_offset == 6'd0 && lk_mask == 9'd0));

  p_lowest_bank_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_mask[lk_bank] && ((lk_mask & ((9'd1 << lk_bank) - 9'd1)) == 9'd0)));

  p_bad_sel_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_we) && $past(cfg_sel) > 4'd8 && $stable(lk_space) && $stable(lk_slot))
      |-> ($stable(lk_mask) && $stable(lk_offset) && $stable(lk_bank)));

  p_offset_in_bank_r12: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_offset < 6'd8));
endmodule

bind vram_bank_map vram_bank_map_chk u_chk (.*);

// File: tb/test_vram_bank_map.sv
`timescale 1ns/1ps
module test_vram_bank_map;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_sel = '0;
  logic [7:0] cfg_data = '0;
  logic [3:0] lk_space = '0;
  logic [5:0] lk_slot = '0;
  logic       lk_hit;
  logic [3:0] lk_bank;
  logic [5:0] lk_offset;
  logic [8:0] lk_mask;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string tag = "R1";
  int mreg [9];

  always #2.5 clk = ~clk;

  vram_bank_map i_vram_bank_map (.*);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 9; b++) mreg[b] <= 0;
    end else if (cfg_we && cfg_sel < 9) begin
      mreg[cfg_sel] <= int'(cfg_data);
    end
  end

  function automatic void claim(input int b, input int r, output int sp, output int st,
                                output int mir, output int sz, output int lim);
    int m, o, ad, pos;
    int base [9] = '{0, 8, 16, 24, 32, 36, 37, 38, 40};
    int bs [9] = '{8, 8, 8, 8, 4, 1, 1, 2, 1};
    m = r & 7;
    o = (r >> 3) & 3;
    ad = o * 8;
    pos = (o == 0) ? 0 : (o == 1) ? 1 : (o == 2) ? 4 : 5;
    sp = -1; st = 0; mir = 64; sz = 1; lim = 0;
    if ((r & 128) == 0) return;
    if (m == 0) begin sp = 0; st = base[b]; lim = 64; sz = bs[b]; return; end
    if (b <= 3 && m == 1) begin sp = 1; st = ad; lim = 32; mir = 32; sz = 8; end
    if (b <= 1 && m == 2 && o < 2) begin sp = 2; st = ad; lim = 32; mir = 16; sz = 8; end
    if ((b == 2 || b == 3) && m == 2 && o < 2) begin sp = 5; st = ad; lim = 16; sz = 8; end
    if (b <= 3 && m == 3) begin sp = 10; st = o; lim = o + 1; end
    if ((b == 2 || b == 3) && m == 4) begin sp = (b == 2) ? 3 : 4; lim = 32; mir = 8; sz = 8; end
    if (b == 4) begin
      sz = 4;
      case (m)
        1: begin sp = 1; lim = 32; mir = 32; end
        2: begin sp = 2; lim = 32; mir = 16; end
        3: begin sp = 11; lim = 4; end
        4: begin sp = 6; lim = 4; end
        default: ;
      endcase
    end
    if (b == 5 || b == 6) begin
      case (m)
        1: begin sp = 1; st = pos; lim = 32; mir = 32; end
        2: begin sp = 2; st = pos; lim = 32; mir = 16; end
        3: begin sp = 11; st = pos; lim = pos + 1; end
        4: begin sp = 6; st = (o & 1) * 2; lim = st + 2; sz = 2; end
        5: begin sp = 8; lim = 1; end
        default: ;
      endcase
    end
    if (b == 7) begin
      if (m == 1) begin sp = 3; lim = 32; mir = 4; sz = 2; end
      if (m == 2) begin sp = 7; lim = 4; sz = 4; end
    end
    if (b == 8) begin
      if (m == 1) begin sp = 3; st = 2; lim = 32; mir = 4; end
      if (m == 2) begin sp = 4; lim = 32; mir = 1; end
      if (m == 3) begin sp = 9; lim = 1; end
    end
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      int sp, st, mir, sz, lim;
      int eb, eo, em, eh;
      eb = 0; eo = 0; em = 0; eh = 0;
      for (int b = 0; b < 9; b++) begin
        claim(b, mreg[b], sp, st, mir, sz, lim);
        if (sp == int'(lk_space)) begin
          for (int j = st; j < lim; j += mir)
            for (int i = 0; i < sz; i++)
              if (j + i == int'(lk_slot) && j + i < lim) begin
                if (eh == 0) begin eb = b; eo = i; end
                eh = 1;
                em = em | (1 << b);
              end
        end
      end
      checks++;
      if (int'(lk_hit) != eh || int'(lk_bank) != eb || int'(lk_offset) != eo || int'(lk_mask) != em) begin
        fails++;
        $display("FAIL %s space=%0d slot=%0d: got hit=%0d bank=%0d off=%0d mask=%h, expected hit=%0d bank=%0d off=%0d mask=%h",
                 tag, lk_space, lk_slot, lk_hit, lk_bank, lk_offset, lk_mask, eh, eb, eo, em);
      end
    end
  end

  task automatic wr(input int sel, input int data);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_data = 8'(data);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic clear_all();
    for (int b = 0; b < 9; b++) wr(b, 0);
  endtask

  task automatic sweep(input string t);
    tag = t;
    for (int sp = 0; sp < 13; sp++)
      for (int sl = 0; sl < 64; sl++) begin
        @(posedge clk); #1;
        lk_space = 4'(sp); lk_slot = 6'(sl);
      end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    sweep("R1");
    for (int b = 0; b < 9; b++) wr(b, 8'h80);
    sweep("R3");
    wr(0, 8'h98);
    sweep("R3");
    clear_all();
    wr(0, 8'h87); wr(1, 8'h01); wr(2, 8'h85); wr(4, 8'h85); wr(5, 8'h86);
    wr(7, 8'h83); wr(8, 8'h84);
    sweep("R9");
    clear_all();
    wr(0, 8'h91); wr(1, 8'h99); wr(2, 8'h81); wr(3, 8'h89);
    sweep("R4");
    clear_all();
    wr(4, 8'h81); wr(5, 8'h99); wr(6, 8'h91);
    sweep("R4");
    clear_all();
    wr(0, 8'h82); wr(1, 8'h8a);
    sweep("R5");
    wr(0, 8'h92); wr(1, 8'h9a); wr(4, 8'h82); wr(5, 8'h8a); wr(6, 8'h9a);
    sweep("R5");
    clear_all();
    wr(2, 8'h82); wr(3, 8'h8a);
    sweep("R6");
    wr(2, 8'h84); wr(3, 8'h84);
    sweep("R6");
    wr(2, 8'h92); wr(3, 8'h9a);
    sweep("R6");
    clear_all();
    wr(7, 8'h81); wr(8, 8'h81);
    sweep("R7");
    wr(7, 8'h82); wr(8, 8'h82);
    sweep("R7");
    wr(8, 8'h83);
    sweep("R7");
    clear_all();
    wr(0, 8'h83); wr(1, 8'h9b); wr(2, 8'h8b); wr(3, 8'h93);
    wr(4, 8'h83); wr(5, 8'h9b); wr(6, 8'h93);
    sweep("R8");
    wr(4, 8'h84); wr(5, 8'h84); wr(6, 8'h8c);
    sweep("R8");
    wr(5, 8'h85); wr(6, 8'h9d);
    sweep("R8");
    clear_all();
    wr(0, 8'h81); wr(4, 8'h81); wr(5, 8'h81); wr(2, 8'h84); wr(7, 8'h81);
    sweep("R10");
    wr(0, 8'h89);
    sweep("R11");
    wr(0, 8'h89);
    sweep("R11");
    wr(4, 8'h00);
    sweep("R11");
    clear_all();
    for (int s = 9; s < 16; s++) wr(s, 8'h81);
    sweep("R2");
    wr(5, 8'h80);
    sweep("R2");
    clear_all();
    wr(3, 8'h84); wr(7, 8'h81); wr(6, 8'h9a);
    sweep("R12");
    tag = "R10";
    for (int n = 0; n < 4000; n++) begin
      @(posedge clk); #1;
      if ($urandom_range(0, 3) == 0) begin
        cfg_we = 1'b1;
        cfg_sel = 4'($urandom_range(0, 11));
        cfg_data = 8'(($urandom & 32'h9f) | (($urandom_range(0, 7) != 0) ? 32'h80 : 32'h0));
      end else begin
        cfg_we = 1'b0;
      end
      lk_space = 4'($urandom_range(0, 12));
      lk_slot = 6'($urandom_range(0, 63));
    end
    @(posedge clk); #1 cfg_we = 1'b0;
    @(posedge clk);
    @(negedge clk);
    #1 done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule